// File: doc/BRIEF.md
# Multi-width arithmetic and flag unit

This block is the subtract and step-arithmetic slice of an execution stage for a register machine whose registers are 32 bits wide and can be used as 8-, 16- or 32-bit operands. One cycle's inputs select an operation, an operand size, a small step code and two 32-bit operands. The result appears combinationally on the same cycle. The condition flags are held in a register inside the block. That register takes the new flag values on the rising clock edge when the write strobe is high.

Each operation rewrites only its own subset of the five flags (half-borrow, negative, zero, overflow, borrow) and keeps the others. The borrow-chained subtract updates zero in a one-way manner, so a chain of byte subtracts can test a multi-byte value for zero. For byte and word sizes the result keeps the destination's upper bits, so the output can be written straight back to a full 32-bit register.

Top module: `arith_flag_unit`

## Requirements
- R1: Opcode 0 (plain subtract) returns destination minus source at the size chosen by sizeSel: 0 is byte, 1 is word, 2 or 3 is long.
- R2: For byte and word results of opcodes 0 to 3, the bits of resultOut above the operand size equal those of dstIn.
- R3: Opcode 0 writes all five flags. The flagsOut bit order is H=4, N=3, Z=2, V=1, C=0. H is the borrow out of bit 3, 11 or 27 for byte, word or long. N is the result's sign bit, Z is set when the result is zero, V flags signed overflow and C is the borrow out of the top bit.
- R4: Opcode 1 (borrow-chained subtract) always works at byte size, whatever sizeSel says. It returns destination minus source minus the stored C and writes H, N, V and C by the rules of R3.
- R5: Under opcode 1, Z keeps its stored value when the byte result is zero and is cleared otherwise. It is never set.
- R6: Opcodes 2 (increment) and 3 (decrement) add or subtract a step and write N, Z and V. At word and long sizes the step is 2 when stepSel is 1 and is 1 otherwise. At byte size the step is always 1.
- R7: Opcodes 2 and 3 leave H and C unchanged.
- R8: Opcode 4 (flag-free address step) always subtracts at 32 bits and changes no flag. The step is 1 for stepSel 0, 2 for stepSel 1, and 4 for stepSel 2 or 3.
- R9: The flag register clears to zero on reset and changes only on a clock edge where flagWe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flagWe | input | 1 | Flag register write strobe |
| opCode | input | 3 | Operation select |
| sizeSel | input | 2 | Operand size select |
| stepSel | input | 2 | Step code for increment, decrement and address step |
| dstIn | input | 32 | Destination operand |
| srcIn | input | 32 | Source operand |
| resultOut | output | 32 | Merged 32-bit result |
| flagsOut | output | 5 | Registered flags {H,N,Z,V,C} |

## Verification
The hardest state to reach is the sticky-zero rule for the borrow-chained subtract. Showing it needs the flag register to hold a known C and a known Z before the operation, and both values are left behind only by earlier operations. The stimulus therefore runs as an ordered chain. A plain subtract that yields zero sets Z, and a following zero-result borrowed subtract must keep it. A borrowed subtract with a nonzero result then clears Z and leaves C set. Finally, a borrowed subtract that uses that C and produces zero must leave Z clear.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int NUM_WIDTHS = 3;
  localparam int BASE_W     = 8;
  localparam int DATA_W     = BASE_W << (NUM_WIDTHS - 1);
  localparam int IDX_W      = $clog2(NUM_WIDTHS);
  localparam int STEP_W     = 3;
  localparam int NUM_FLAGS  = 5;

  localparam int FLAG_H = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [2:0] {
    OP_SUB  = 3'd0,
    OP_SUBB = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_ASTEP = 3'd4
  } opCodeT;

  typedef struct packed {
    logic              doAdd;
    logic              useCarry;
    logic              useStep;
    logic [STEP_W-1:0] stepVal;
    logic [IDX_W-1:0]  widthIdx;
    logic              updH;
    logic              updN;
    logic              updZ;
    logic              updV;
    logic              updC;
    logic              zSticky;
  } ctrlStrobesT;
endpackage

// File: rtl/afu_control.sv
module afu_control
  import afu_pkg::*;
(
  input  logic [2:0] opCode,
  input  logic [1:0] sizeSel,
  input  logic [1:0] stepSel,
  output ctrlStrobesT strobes
);
  logic [IDX_W-1:0] sizeIdx;
  logic [STEP_W-1:0] incStep;
  logic [STEP_W-1:0] addrStep;

  always_comb begin
    sizeIdx = (sizeSel == 2'd0) ? IDX_W'(0) :
              (sizeSel == 2'd1) ? IDX_W'(1) : IDX_W'(NUM_WIDTHS - 1);
    incStep = (sizeIdx != '0 && stepSel == 2'd1) ? STEP_W'(2) : STEP_W'(1);
    case (stepSel)
      2'd0:    addrStep = STEP_W'(1);
      2'd1:    addrStep = STEP_W'(2);
      default: addrStep = STEP_W'(4);
    endcase
  end

  always_comb begin
    strobes = '0;
    strobes.widthIdx = IDX_W'(NUM_WIDTHS - 1);
    strobes.useStep  = 1'b1;
    case (opCode)
      OP_SUB: begin
        strobes.useStep  = 1'b0;
        strobes.widthIdx = sizeIdx;
        strobes.updH = 1'b1;
        strobes.updN = 1'b1;
        strobes.updZ = 1'b1;
        strobes.updV = 1'b1;
        strobes.updC = 1'b1;
      end
      OP_SUBB: begin
        strobes.useStep  = 1'b0;
        strobes.useCarry = 1'b1;
        strobes.widthIdx = '0;
        strobes.updH = 1'b1;
        strobes.updN = 1'b1;
        strobes.updV = 1'b1;
        strobes.updC = 1'b1;
        strobes.zSticky = 1'b1;
      end
      OP_INC, OP_DEC: begin
        strobes.doAdd    = (opCode == OP_INC);
        strobes.stepVal  = incStep;
        strobes.widthIdx = sizeIdx;
        strobes.updN = 1'b1;
        strobes.updZ = 1'b1;
        strobes.updV = 1'b1;
      end
      OP_ASTEP: begin
        strobes.stepVal = addrStep;
      end
      default: begin
        strobes.stepVal = '0;
      end
    endcase
  end
endmodule

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flagWe,
  input  ctrlStrobesT          strobes,
  input  logic [DATA_W-1:0]    dstIn,
  input  logic [DATA_W-1:0]    srcIn,
  output logic [DATA_W-1:0]    resultOut,
  output logic [NUM_FLAGS-1:0] flagsOut
);
  logic [NUM_FLAGS-1:0] flagReg;
  logic [NUM_FLAGS-1:0] nextFlags;

  logic [DATA_W-1:0] mergedRes [NUM_WIDTHS];
  logic [NUM_WIDTHS-1:0] halfB, signR, zeroR, ovfR, borrowR;

  logic carryIn;
  assign carryIn = strobes.useCarry & flagReg[FLAG_C];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : gWidth
    localparam int W = BASE_W << g;
    localparam int HB = W - 4;
    logic [W-1:0] opA;
    logic [W-1:0] opB;
    logic [W:0]   full;
    logic [HB:0]  half;

    assign opA = dstIn[W-1:0];
    assign opB = strobes.useStep ? W'(strobes.stepVal) : srcIn[W-1:0];

    always_comb begin
      if (strobes.doAdd) begin
        full = {1'b0, opA} + {1'b0, opB};
        half = {1'b0, opA[HB-1:0]} + {1'b0, opB[HB-1:0]};
      end else begin
        full = {1'b0, opA} - {1'b0, opB} - (W+1)'(carryIn);
        half = {1'b0, opA[HB-1:0]} - {1'b0, opB[HB-1:0]} - (HB+1)'(carryIn);
      end
    end

    assign halfB[g]   = half[HB];
    assign signR[g]   = full[W-1];
    assign zeroR[g]   = (full[W-1:0] == '0);
    assign borrowR[g] = full[W];
    assign ovfR[g]    = strobes.doAdd
                      ? ((opA[W-1] == opB[W-1]) && (full[W-1] != opA[W-1]))
                      : ((opA[W-1] != opB[W-1]) && (full[W-1] != opA[W-1]));

    if (W < DATA_W) begin : gMerge
      assign mergedRes[g] = {dstIn[DATA_W-1:W], full[W-1:0]};
    end else begin : gFull
      assign mergedRes[g] = full[W-1:0];
    end
  end

  logic hSel, nSel, zSel, vSel, cSel;
  always_comb begin
    resultOut = mergedRes[strobes.widthIdx];
    hSel = halfB[strobes.widthIdx];
    nSel = signR[strobes.widthIdx];
    zSel = zeroR[strobes.widthIdx];
    vSel = ovfR[strobes.widthIdx];
    cSel = borrowR[strobes.widthIdx];
  end

  always_comb begin
    nextFlags = flagReg;
    if (strobes.updH) nextFlags[FLAG_H] = hSel;
    if (strobes.updN) nextFlags[FLAG_N] = nSel;
    if (strobes.updV) nextFlags[FLAG_V] = vSel;
    if (strobes.updC) nextFlags[FLAG_C] = cSel;
    if (strobes.zSticky)   nextFlags[FLAG_Z] = zSel & flagReg[FLAG_Z];
    else if (strobes.updZ) nextFlags[FLAG_Z] = zSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flagReg <= '0;
    else if (flagWe) flagReg <= nextFlags;
  end

  assign flagsOut = flagReg;
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flagWe,
  input  logic [2:0]           opCode,
  input  logic [1:0]           sizeSel,
  input  logic [1:0]           stepSel,
  input  logic [DATA_W-1:0]    dstIn,
  input  logic [DATA_W-1:0]    srcIn,
  output logic [DATA_W-1:0]    resultOut,
  output logic [NUM_FLAGS-1:0] flagsOut
);
  ctrlStrobesT strobes;

  afu_control uCtrl (
    .opCode (opCode),
    .sizeSel(sizeSel),
    .stepSel(stepSel),
    .strobes(strobes)
  );

  afu_datapath uPath (
    .clk      (clk),
    .rstN     (rstN),
    .flagWe   (flagWe),
    .strobes  (strobes),
    .dstIn    (dstIn),
    .srcIn    (srcIn),
    .resultOut(resultOut),
    .flagsOut (flagsOut)
  );
endmodule

// File: rtl/afu_checker.sv
module afu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        flagWe,
  input logic [2:0]  opCode,
  input logic [1:0]  sizeSel,
  input logic [31:0] dstIn,
  input logic [31:0] resultOut,
  input logic [4:0]  flagsOut
);
  // R9
  hold_without_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> $stable(flagsOut));

  // R8
  astep_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && opCode == 3'd4) |=> $stable(flagsOut));

  // R7
  step_keeps_hc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && (opCode == 3'd2 || opCode == 3'd3))
      |=> (flagsOut[4] == $past(flagsOut[4]) && flagsOut[0] == $past(flagsOut[0])));

  // R5
  sticky_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && opCode == 3'd1) |=> !$rose(flagsOut[2]));

  // R2
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((opCode == 3'd1) || (opCode <= 3'd3 && sizeSel == 2'd0))
      |-> resultOut[31:8] == dstIn[31:8]);

  // R2
  word_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode != 3'd1 && opCode <= 3'd3 && sizeSel == 2'd1)
      |-> resultOut[31:16] == dstIn[31:16]);
endmodule

bind arith_flag_unit afu_checker uChk (
  .clk(clk), .rstN(rstN), .flagWe(flagWe), .opCode(opCode),
  .sizeSel(sizeSel), .dstIn(dstIn), .resultOut(resultOut), .flagsOut(flagsOut)
);

// File: tb/tb_arith_flag_unit.sv
module tb_arith_flag_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flagWe = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  sizeSel = '0;
  logic [1:0]  stepSel = '0;
  logic [31:0] dstIn = '0;
  logic [31:0] srcIn = '0;
  logic [31:0] resultOut;
  logic [4:0]  flagsOut;

  int errCnt = 0;
  int chkCnt = 0;

  always #2 clk = ~clk;

  arith_flag_unit dut (
    .clk(clk), .rstN(rstN), .flagWe(flagWe), .opCode(opCode),
    .sizeSel(sizeSel), .stepSel(stepSel), .dstIn(dstIn), .srcIn(srcIn),
    .resultOut(resultOut), .flagsOut(flagsOut)
  );

  // {op, size, step, dst, src, expected result, expected flags {H,N,Z,V,C}}
  localparam int NV = 16;
  localparam logic [107:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'd0, 32'h12345678, 32'h00000078, 32'h12345600, 5'b00100}, // R1 R3 byte zero
    {3'd0, 2'd0, 2'd0, 32'hAABBCC00, 32'h00000001, 32'hAABBCCFF, 5'b11001}, // R2 R3 byte borrow
    {3'd1, 2'd0, 2'd0, 32'h00000010, 32'h00000005, 32'h0000000A, 5'b10000}, // R4 uses C=1
    {3'd0, 2'd1, 2'd0, 32'hFFFF8000, 32'h00000001, 32'hFFFF7FFF, 5'b10010}, // R3 word ovf
    {3'd0, 2'd2, 2'd0, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 5'b11001}, // R1 long
    {3'd2, 2'd0, 2'd1, 32'h1234567F, 32'h00000000, 32'h12345680, 5'b11011}, // R6 R7 inc byte
    {3'd3, 2'd1, 2'd1, 32'h00000001, 32'h00000000, 32'h0000FFFF, 5'b11001}, // R6 dec word by 2
    {3'd2, 2'd2, 2'd1, 32'hFFFFFFFE, 32'h00000000, 32'h00000000, 5'b10101}, // R6 inc long by 2
    {3'd4, 2'd0, 2'd2, 32'h00000002, 32'h00000000, 32'hFFFFFFFE, 5'b10101}, // R8 step 4
    {3'd3, 2'd0, 2'd1, 32'h00000080, 32'h00000000, 32'h0000007F, 5'b10011}, // R6 byte step forced 1
    {3'd0, 2'd0, 2'd0, 32'h00000005, 32'h00000005, 32'h00000000, 5'b00100}, // R3 set Z
    {3'd1, 2'd0, 2'd0, 32'h00000000, 32'h00000000, 32'h00000000, 5'b00100}, // R5 Z kept
    {3'd1, 2'd0, 2'd0, 32'h00000000, 32'h000000FF, 32'h00000001, 5'b10001}, // R5 Z cleared
    {3'd1, 2'd0, 2'd0, 32'h00000001, 32'h00000000, 32'h00000000, 5'b00000}, // R5 zero stays clear
    {3'd0, 2'd1, 2'd0, 32'hABCD1234, 32'h00001234, 32'hABCD0000, 5'b00100}, // R2 word upper
    {3'd4, 2'd0, 2'd0, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 5'b00100}  // R8 step 1
  };

  task automatic checkRes(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string tag, input logic [4:0] act, input logic [4:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s flags act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic applyOp(input logic [2:0] op, input logic [1:0] sz, input logic [1:0] st,
                         input logic [31:0] d, input logic [31:0] s, input logic we);
    @(negedge clk);
    opCode = op; sizeSel = sz; stepSel = st; dstIn = d; srcIn = s; flagWe = we;
    #1;
  endtask

  initial begin
    #200000;
    errCnt++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkFlags("R9 reset", flagsOut, 5'b00000);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      applyOp(VEC[i][107:105], VEC[i][104:103], VEC[i][102:101],
              VEC[i][100:69], VEC[i][68:37], 1'b1);
      checkRes($sformatf("R1/R2/R4/R6/R8 vec%0d", i), resultOut, VEC[i][36:5]);
      @(posedge clk); #1;
      checkFlags($sformatf("R3/R5/R7/R8 vec%0d", i), flagsOut, VEC[i][4:0]);
    end

    // R9: write strobe low keeps the flags
    applyOp(3'd0, 2'd0, 2'd0, 32'h00000000, 32'h00000001, 1'b0);
    checkRes("R1 no-we", resultOut, 32'h000000FF);
    @(posedge clk); #1;
    checkFlags("R9 no-we hold", flagsOut, 5'b00100);

    // R4: long size request still works on the low byte
    applyOp(3'd1, 2'd2, 2'd0, 32'h12345620, 32'h00000010, 1'b1);
    checkRes("R4 forced byte", resultOut, 32'h12345610);
    @(posedge clk); #1;
    checkFlags("R4 forced byte", flagsOut, 5'b00000);

    // R3: long half-borrow from bit 27 only
    applyOp(3'd0, 2'd2, 2'd0, 32'h10000000, 32'h00000001, 1'b1);
    checkRes("R3 long H", resultOut, 32'h0FFFFFFF);
    @(posedge clk); #1;
    checkFlags("R3 long H", flagsOut, 5'b10000);

    // R9: reset in mid run clears flags
    @(negedge clk); flagWe = 1'b0; rstN = 1'b0;
    #1;
    checkFlags("R9 mid reset", flagsOut, 5'b00000);
    rstN = 1'b1;

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule